// File: doc/BRIEF.md
# Skewed-Strobe Delay Test Sequencer

This controller runs from the fast rated clock. It lets a tester that delivers vectors slowly still expose path delays that only show at speed. The device flip-flops are enabled on every rated cycle. New stimulus, however, is taken only once per slow test period of N rated cycles. The device outputs are sampled a chosen number of rated cycles after each new stimulus. The whole vector set is replayed N times, and the sample point moves one rated cycle later on each replay. Over the N replays, one slow sample covers every fast-cycle offset.

Vectors and their expected responses come from an external source through a valid/ready handshake. The source presents the entry selected by `req_idx`. At each sample the device output word is compared with the expected word. The first mismatch is kept together with its replay number and vector index. A start pulse loads the replay count N and the number of vectors V. The block then runs unattended and raises a one-cycle done pulse after the final replay.

Top module: `skew_strobe_seq`

## Requirements
- R1: After synchronous reset the block is idle, with `busy`, `done`, `src_ready`, `strobe`, `dut_ff_en` and `fail` all low and `pass_num` equal to 1.
- R2: A start pulse taken while idle latches N from `n_sel` and V from `vec_cnt`. An `n_sel` of 0 is treated as 1 and a value above NMAX (16) as NMAX. A `vec_cnt` of 0 is treated as 1.
- R3: `src_ready` is high only at a test-period boundary of a running sequence. A vector is applied to `dut_vec` on the edge where `src_ready` and `src_valid` are both high. With a source that is always valid, successive acceptances are exactly N cycles apart, and the first one falls on the edge after the start edge.
- R4: While `src_ready` is high and `src_valid` is low, the phase timing is frozen. `src_ready` stays high, `dut_vec` holds and no strobe fires. Timing resumes from the next acceptance.
- R5: In replay k (1..N), `strobe` marks the cycle whose closing edge samples `dut_out`. That edge is exactly k cycles after the acceptance edge of the vector.
- R6: Replays run k = 1..N in order. Each replay requests indices 0..V-1 in order on `req_idx`, so there are N·V acceptances and N·V strobes. `pass_num` gives the replay of the vector in flight.
- R7: `dut_ff_en` is high in every cycle while `busy` is high, and low while idle.
- R8: A strobe whose sample differs from the expected word of that vector sets `fail`. The same strobe records the replay number in `fail_pass` and the vector index in `fail_idx`. Later mismatches leave all three unchanged until the next accepted start.
- R9: A start pulse while busy is ignored: N, V and the run length are unchanged.
- R10: `done` is a one-cycle pulse. It comes one cycle after the final boundary, which follows the last strobe of replay N, and the block is idle in that cycle. Without stalls, the done cycle comes N·N·V + 2 cycles after the start cycle. Each stalled cycle adds one.
- R11: An accepted start clears `fail`, `fail_pass` and `fail_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rated clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, honoured only while idle |
| n_sel | input | N_W | Requested replay count / speed reduction factor |
| vec_cnt | input | IDX_W | Number of vectors in the set |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle completion pulse |
| src_valid | input | 1 | Source holds the requested vector |
| src_ready | output | 1 | Boundary: vector may be taken now |
| req_idx | output | IDX_W | Index of the vector requested from the source |
| src_vec | input | IN_W | Stimulus word from the source |
| src_exp | input | OUT_W | Expected response word from the source |
| dut_vec | output | IN_W | Stimulus held at the device inputs |
| dut_ff_en | output | 1 | Device flip-flop enable, every rated cycle while busy |
| dut_out | input | OUT_W | Device output word |
| strobe | output | 1 | Closing edge of this cycle samples `dut_out` |
| pass_num | output | N_W | Replay number of the vector in flight |
| fail | output | 1 | Sticky mismatch flag |
| fail_pass | output | N_W | Replay number of the first mismatch |
| fail_idx | output | IDX_W | Vector index of the first mismatch |

## Verification
The bench builds the sequencer with its default widths and NMAX of 16. It feeds the block from a behavioural device whose output latency is set per run, from 0 up to N cycles. With this range, early strobes in the first replays see the previous vector and later ones see the new vector. Each run therefore has a predictable first failing replay and index. N is driven over 0 (clamped), 1, 4, 16 and 20 (clamped), together with random mid values and random source stalls. This covers the degenerate at-speed case, the deepest replay, and the frozen-phase path.

// File: rtl/skew_seq_pkg.sv
package skew_seq_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  // Replay count: 0 means 1, anything above the ceiling means the ceiling.
  function automatic int unsigned clamp_n(int unsigned raw, int unsigned nmax);
    if (raw == 0) return 1;
    if (raw > nmax) return nmax;
    return raw;
  endfunction

  // Index of the final vector for a requested count (count 0 means one vector).
  function automatic int unsigned last_index(int unsigned cnt);
    return (cnt == 0) ? 0 : cnt - 1;
  endfunction

endpackage

// File: rtl/ssq_phase.sv
module ssq_phase #(
  parameter int N_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           busy,
  input  logic           accept,
  input  logic [N_W-1:0] n_load,
  input  logic [N_W-1:0] n_q,
  input  logic [N_W-1:0] k_cur,
  output logic           strobe_now,
  output logic           boundary
);
  logic [N_W-1:0] cnt;      // rated cycles since the last acceptance, saturates at N
  logic           strobed;  // sample for the vector in flight already taken

  assign strobe_now = busy && !strobed && (cnt == k_cur);
  assign boundary   = busy && (cnt == n_q) && (strobed || strobe_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      strobed <= 1'b1;
    end else if (go) begin
      cnt     <= n_load;
      strobed <= 1'b1;
    end else if (busy) begin
      if (accept) begin
        cnt     <= N_W'(1);
        strobed <= 1'b0;
      end else begin
        if (cnt != n_q) cnt <= cnt + 1'b1;
        if (strobe_now) strobed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssq_iter.sv
module ssq_iter #(
  parameter int N_W   = 5,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             accept,
  input  logic [IDX_W-1:0] last_q,
  input  logic [N_W-1:0]   n_q,
  output logic [IDX_W-1:0] req_idx,
  output logic [IDX_W-1:0] cur_idx,
  output logic [N_W-1:0]   cur_pass,
  output logic             pass_over
);
  logic [N_W-1:0] req_pass;
  logic           wrap;

  assign wrap      = (req_idx == last_q);
  assign pass_over = (req_pass > n_q);

  always_ff @(posedge clk) begin
    if (rst || go) begin
      req_idx  <= '0;
      req_pass <= N_W'(1);
      cur_idx  <= '0;
      cur_pass <= N_W'(1);
    end else if (accept) begin
      cur_idx  <= req_idx;
      cur_pass <= req_pass;
      if (wrap) begin
        req_idx  <= '0;
        req_pass <= req_pass + 1'b1;
      end else begin
        req_idx  <= req_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssq_judge.sv
module ssq_judge #(
  parameter int N_W   = 5,
  parameter int IDX_W = 10,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             accept,
  input  logic             strobe_now,
  input  logic [OUT_W-1:0] src_exp,
  input  logic [OUT_W-1:0] dut_out,
  input  logic [N_W-1:0]   cur_pass,
  input  logic [IDX_W-1:0] cur_idx,
  output logic             mismatch,
  output logic             fail,
  output logic [N_W-1:0]   fail_pass,
  output logic [IDX_W-1:0] fail_idx
);
  logic [OUT_W-1:0] exp_q;

  assign mismatch = strobe_now && (dut_out != exp_q);

  always_ff @(posedge clk) begin
    if (rst) exp_q <= '0;
    else if (accept) exp_q <= src_exp;
  end

  always_ff @(posedge clk) begin
    if (rst || go) begin
      fail      <= 1'b0;
      fail_pass <= '0;
      fail_idx  <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_pass <= cur_pass;
      fail_idx  <= cur_idx;
    end
  end
endmodule

// File: rtl/skew_strobe_seq.sv
module skew_strobe_seq #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter int IDX_W = 10,
  parameter int NMAX  = 16,
  parameter int N_W   = $clog2(NMAX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N_W-1:0]   n_sel,
  input  logic [IDX_W-1:0] vec_cnt,
  output logic             busy,
  output logic             done,
  input  logic             src_valid,
  output logic             src_ready,
  output logic [IDX_W-1:0] req_idx,
  input  logic [IN_W-1:0]  src_vec,
  input  logic [OUT_W-1:0] src_exp,
  output logic [IN_W-1:0]  dut_vec,
  output logic             dut_ff_en,
  input  logic [OUT_W-1:0] dut_out,
  output logic             strobe,
  output logic [N_W-1:0]   pass_num,
  output logic             fail,
  output logic [N_W-1:0]   fail_pass,
  output logic [IDX_W-1:0] fail_idx
);
  import skew_seq_pkg::*;

  seq_state_t       state;
  logic [N_W-1:0]   n_q, n_load;
  logic [IDX_W-1:0] last_q, cur_idx;
  logic [N_W-1:0]   cur_pass;
  logic             go, accept, boundary, strobe_now, pass_over, done_now, mismatch;

  assign busy      = (state == ST_RUN);
  assign go        = start && !busy;
  assign n_load    = N_W'(clamp_n(32'(n_sel), NMAX));
  assign src_ready = boundary && !pass_over;
  assign accept    = src_ready && src_valid;
  assign done_now  = boundary && pass_over;
  assign dut_ff_en = busy;
  assign strobe    = strobe_now;
  assign pass_num  = cur_pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      n_q    <= N_W'(1);
      last_q <= '0;
      done   <= 1'b0;
      dut_vec <= '0;
    end else begin
      done <= done_now;
      if (go) begin
        state  <= ST_RUN;
        n_q    <= n_load;
        last_q <= IDX_W'(last_index(32'(vec_cnt)));
      end else if (done_now) begin
        state <= ST_IDLE;
      end
      if (accept) dut_vec <= src_vec;
    end
  end

  ssq_phase #(.N_W(N_W)) u_phase (
    .clk(clk), .rst(rst), .go(go), .busy(busy), .accept(accept),
    .n_load(n_load), .n_q(n_q), .k_cur(cur_pass),
    .strobe_now(strobe_now), .boundary(boundary)
  );

  ssq_iter #(.N_W(N_W), .IDX_W(IDX_W)) u_iter (
    .clk(clk), .rst(rst), .go(go), .accept(accept), .last_q(last_q), .n_q(n_q),
    .req_idx(req_idx), .cur_idx(cur_idx), .cur_pass(cur_pass), .pass_over(pass_over)
  );

  ssq_judge #(.N_W(N_W), .IDX_W(IDX_W), .OUT_W(OUT_W)) u_judge (
    .clk(clk), .rst(rst), .go(go), .accept(accept), .strobe_now(strobe_now),
    .src_exp(src_exp), .dut_out(dut_out), .cur_pass(cur_pass), .cur_idx(cur_idx),
    .mismatch(mismatch), .fail(fail), .fail_pass(fail_pass), .fail_idx(fail_idx)
  );
endmodule

// File: rtl/ssq_chk.sv
module ssq_chk #(
  parameter int IN_W  = 8,
  parameter int IDX_W = 10,
  parameter int N_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             src_valid,
  input logic             src_ready,
  input logic [IN_W-1:0]  dut_vec,
  input logic             strobe,
  input logic [N_W-1:0]   pass_num,
  input logic             fail,
  input logic [N_W-1:0]   fail_pass,
  input logic [IDX_W-1:0] fail_idx,
  input logic             go,
  input logic [N_W-1:0]   n_q
);
  // R3
  ready_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    src_ready |-> busy);

  // R4
  stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (src_ready && !src_valid) |=> (src_ready && !strobe && $stable(dut_vec)));

  // R5
  strobe_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> busy);

  // R6
  pass_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pass_num >= 1 && pass_num <= n_q));

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !go) |=> (fail && $stable(fail_pass) && $stable(fail_idx)));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(n_q));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind skew_strobe_seq ssq_chk #(.IN_W(IN_W), .IDX_W(IDX_W), .N_W(N_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .src_valid(src_valid), .src_ready(src_ready), .dut_vec(dut_vec), .strobe(strobe),
  .pass_num(pass_num), .fail(fail), .fail_pass(fail_pass), .fail_idx(fail_idx),
  .go(go), .n_q(n_q)
);

// File: tb/skew_strobe_seq_test.sv
module skew_strobe_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 8, OUT_W = 8, IDX_W = 10, NMAX = 16, N_W = $clog2(NMAX + 2);
  localparam logic [7:0] KEY = 8'hA5;

  logic clk = 0, rst = 1, start = 0, src_valid = 0;
  logic [N_W-1:0] n_sel = '0;
  logic [IDX_W-1:0] vec_cnt = '0;
  logic busy, done, src_ready, dut_ff_en, strobe, fail;
  logic [IDX_W-1:0] req_idx, fail_idx;
  logic [IN_W-1:0] src_vec, dut_vec;
  logic [OUT_W-1:0] src_exp, dut_out;
  logic [N_W-1:0] pass_num, fail_pass;

  logic [7:0] vecs [16];
  logic [7:0] chain [16];
  int dly = 0, vpct = 100;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign src_vec = vecs[req_idx[3:0]];
  assign src_exp = vecs[req_idx[3:0]] ^ KEY;
  assign dut_out = ((dly == 0) ? dut_vec : chain[dly-1]) ^ KEY;

  always @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < 16; j++) chain[j] <= '0;
    end else if (dut_ff_en) begin
      chain[0] <= dut_vec;
      for (int j = 1; j < 16; j++) chain[j] <= chain[j-1];
    end
  end

  skew_strobe_seq uut (
    .clk(clk), .rst(rst), .start(start), .n_sel(n_sel), .vec_cnt(vec_cnt),
    .busy(busy), .done(done), .src_valid(src_valid), .src_ready(src_ready),
    .req_idx(req_idx), .src_vec(src_vec), .src_exp(src_exp), .dut_vec(dut_vec),
    .dut_ff_en(dut_ff_en), .dut_out(dut_out), .strobe(strobe), .pass_num(pass_num),
    .fail(fail), .fail_pass(fail_pass), .fail_idx(fail_idx)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  // per-run model state
  int en = 1, ev = 1;
  int acc_n, stb_n, stalls, acc_cyc, start_cyc, done_cyc, done_seen;
  int b_pass, b_idx, cur_v, last_applied = 0;
  int pf, pf_pass, pf_idx, strobe_pending;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int clampn(int raw);
    return (raw < 1) ? 1 : ((raw > NMAX) ? NMAX : raw);
  endfunction

  // drive valid at negedge, then observe settled values
  always @(negedge clk) begin
    src_valid = ($urandom % 100) < vpct;
    #1;
    cyc++;
    if (!rst) begin
      if (start && !busy) start_cyc = cyc;
      if (busy) chk(dut_ff_en == 1'b1, "R7 ff enable while busy", dut_ff_en, 1);
      if (!busy && !done) chk(dut_ff_en == 1'b0, "R7 ff enable idle", dut_ff_en, 0);
      if (src_ready && !src_valid) stalls++;
      if (strobe) begin
        stb_n++;
        chk(cyc - acc_cyc == b_pass, "R5 strobe offset", cyc - acc_cyc, b_pass);
        if (pf == 0 && b_pass <= dly && cur_v != last_applied_prev) begin
          pf = 1; pf_pass = b_pass; pf_idx = b_idx;
        end
      end
      if (src_ready && src_valid) begin
        b_idx = acc_n % ev;
        b_pass = acc_n / ev + 1;
        if (acc_n > 0 && stalls == stalls_at_last)
          chk(cyc - acc_cyc == en, "R3 accept spacing", cyc - acc_cyc, en);
        chk(int'(req_idx) == b_idx, "R6 requested index", req_idx, b_idx);
        stalls_at_last = stalls;
        acc_cyc = cyc;
        acc_n++;
        last_applied_prev = last_applied;
        cur_v = vecs[b_idx];
        last_applied = cur_v;
      end
      if (done) begin
        done_seen++;
        if (done_seen == 1) done_cyc = cyc;
      end
    end
  end

  int last_applied_prev = 0;
  int stalls_at_last = 0;

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0; last_applied = 0; last_applied_prev = 0;
  endtask

  task automatic run_case(input int n_raw, input int v, input int d, input int pct,
                          input bit poke, input string tag);
    int n;
    n = clampn(n_raw);
    en = n; ev = (v < 1) ? 1 : v; dly = d; vpct = pct;
    for (int j = 0; j < 16; j++) vecs[j] = 8'($urandom);
    acc_n = 0; stb_n = 0; stalls = 0; stalls_at_last = 0; done_seen = 0;
    pf = 0; pf_pass = 0; pf_idx = 0; done_cyc = 0; acc_cyc = 0;
    @(negedge clk);
    n_sel = N_W'(n_raw); vec_cnt = IDX_W'(v);
    pulse_start();
    if (poke) begin
      repeat (3) @(negedge clk);
      n_sel = N_W'(n_raw + 3); vec_cnt = IDX_W'(v + 2);
      pulse_start(); // R9 ignored while busy
    end
    for (int t = 0; t < 30000 && done_seen == 0; t++) @(negedge clk);
    chk(done_seen == 1, {tag, " R10 done seen"}, done_seen, 1);
    repeat (3) @(negedge clk);
    chk(done_seen == 1, {tag, " R10 done single pulse"}, done_seen, 1);
    chk(!busy, {tag, " R10 idle after done"}, busy, 0);
    chk(acc_n == n * ev, {tag, " R6/R9 accept count"}, acc_n, n * ev);
    chk(stb_n == n * ev, {tag, " R6 strobe count"}, stb_n, n * ev);
    chk(done_cyc - start_cyc == 2 + n * n * ev + stalls,
        {tag, " R10/R2 run length"}, done_cyc - start_cyc, 2 + n * n * ev + stalls);
    chk(fail == pf, {tag, " R8 fail flag"}, fail, pf);
    if (pf != 0) begin
      chk(int'(fail_pass) == pf_pass, {tag, " R8 fail pass"}, fail_pass, pf_pass);
      chk(int'(fail_idx) == pf_idx, {tag, " R8 fail index"}, fail_idx, pf_idx);
    end
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !src_ready && !strobe && !dut_ff_en, "R1 idle outputs",
        {busy, done, src_ready, strobe, dut_ff_en}, 0);
    chk(int'(pass_num) == 1, "R1 pass number", pass_num, 1);
    chk(!fail, "R1 fail clear", fail, 0);

    run_case(4, 5, 2, 100, 0, "n4");          // R3 R5 mismatches in early replays
    run_case(1, 3, 0, 100, 0, "n1");          // at-speed case
    run_case(0, 2, 0, 100, 0, "n0clamp");     // R2 zero -> 1
    do_reset();
    run_case(20, 1, 3, 100, 0, "n20clamp");   // R2 above ceiling -> 16
    run_case(3, 0, 1, 100, 0, "v0clamp");     // R2 zero vectors -> 1
    run_case(4, 3, 4, 60, 0, "stall");        // R4 stalls with deepest latency
    run_case(3, 4, 2, 100, 1, "poke");        // R9 start while busy
    // R11: a failing run, then a clean run clears the record
    run_case(2, 3, 2, 100, 0, "pre");
    run_case(2, 3, 0, 100, 0, "R11 clear");
    chk(!fail && fail_pass == 0 && fail_idx == 0, "R11 record cleared",
        {fail, fail_pass}, 0);

    for (int r = 0; r < 6; r++) begin
      int n, v;
      n = 1 + ($urandom % 6);
      v = 1 + ($urandom % 6);
      do_reset();
      run_case(n, v, $urandom % (n + 1), 50 + ($urandom % 51), 0, "rand");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    process::self(); // keep
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule